// File: doc/BRIEF.md
# Radix-4 Booth Partial Product Generator

This block takes a signed multiplier operand and a signed multiplicand operand. It produces the weighted partial-product bits of their two's-complement product. It recodes the multiplier into radix-4 digits in the range -2 to +2, one digit for every two multiplier bits. For each digit it selects zero, the multiplicand, or the multiplicand shifted left by one, and inverts the selection when the digit is negative. Each negative row also raises a separate negation flag. That flag stands for a single 1 at the row's base weight, and it completes the two's complement of the row.

The block does not replicate sign bits across each row. Instead it folds the sign extension into a few fixed bits. The first row gets a copy of its top bit and, one weight higher, the inverse of that bit. Every later row has its top bit inverted and a constant 1 placed just above it. Each row is delivered already placed at its weight inside a product-wide vector. Any bit that would land at or above the product width is dropped. A downstream compressor tree sums all rows and all negation flags modulo 2^(XW+YW), and that sum is the signed product. This block performs no reduction and no addition itself.

Inputs are sampled when `in_valid` is high, and the registered results appear one clock later. The outputs keep their value while no new operand pair arrives.

Top module: `booth_pp_gen`

## Requirements
- R1: While `rst` is high at a clock edge, `out_valid`, every row of `rows_o` and every bit of `neg_o` become 0 on that edge.
- R2: An operand pair sampled with `in_valid` high appears on `rows_o`/`neg_o` with `out_valid` high exactly one clock later. After an edge where `in_valid` was low, `out_valid` is low and `rows_o` and `neg_o` keep their previous values.
- R3: Row r uses the triplet (hi, mid, lo) = (xe[2r+2], xe[2r+1], xe[2r]), where xe is the multiplier with a 0 appended below bit 0 and its sign bit repeated above. Bit j (0..YW) of the row is chosen from ye, the multiplicand extended in the same way, where y[j] means ye[j+1] and y[j-1] means ye[j]. Triplets 000 and 111 give 0. Triplets 001 and 010 give y[j]. Triplet 011 gives y[j-1]. Triplet 100 gives NOT y[j-1]. Triplets 101 and 110 give NOT y[j]. Bits 0..YW of row 0 appear unmodified at weights 0..YW.
- R4: `neg_o[r]` is hi AND (NOT mid OR NOT lo). It is 1 exactly for triplets 100, 101 and 110, and it stands for a 1 at weight 2r.
- R5: Row r occupies `rows_o[r*PW +: PW]` with its bit j at weight 2r+j, and every bit below weight 2r is 0.
- R6: In row 0, weight YW+1 holds a copy of the row's bit YW and weight YW+2 holds its inverse; all weights above YW+2 are 0.
- R7: In every row r > 0, weight 2r+YW holds the inverse of the selected bit YW, weight 2r+YW+1 holds a constant 1, and all higher weights are 0; any of these at weight PW or above is dropped.
- R8: The sum of all rows plus neg_o[r]·2^(2r) for every r, taken modulo 2^PW, equals the signed product of the two operands modulo 2^PW, for every operand pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand pair present this cycle |
| x_i | input | XW | Signed multiplier operand (recoded into digits) |
| y_i | input | YW | Signed multiplicand operand (selected per digit) |
| out_valid | output | 1 | Rows and flags below hold a new result |
| rows_o | output | NR*PW | NR rows of PW bits each, row r at bits r*PW upward, already weighted |
| neg_o | output | NR | Per-row negation flag, weight 2r |

## Verification
The delicate cycle is one in which the top row both carries a negative digit and loses bits to truncation. Its inverted top bit, its negation flag and its constant 1 all fall in the same result, and with an odd multiplier width that constant 1 sits exactly at weight PW and must be dropped. The bench drives every operand pair at the default 5-by-6 widths, which covers all triplets in the top row together with every multiplicand pattern. It judges each result both bit by bit against a digit value computed arithmetically and as a whole through the modular sum of rows and flags against the signed product. Idle cycles with changed operands are mixed into the stream to show that the outputs hold.

// File: rtl/booth_pp_pkg.sv
package booth_pp_pkg;

  // Decoded radix-4 digit: magnitude one, magnitude two, negative.
  typedef struct packed {
    logic one;
    logic two;
    logic neg;
  } booth_sel_t;

endpackage

// File: rtl/booth_digit_dec.sv
module booth_digit_dec
  import booth_pp_pkg::*;
(
  input  logic [2:0]  trip_i,   // {hi, mid, lo}
  output booth_sel_t  sel_o
);

  always_comb begin
    sel_o = '0;
    unique case (trip_i)
      3'b001, 3'b010: sel_o.one = 1'b1;
      3'b011:         sel_o.two = 1'b1;
      3'b100: begin
        sel_o.two = 1'b1;
        sel_o.neg = 1'b1;
      end
      3'b101, 3'b110: begin
        sel_o.one = 1'b1;
        sel_o.neg = 1'b1;
      end
      default:        sel_o = '0;   // 000 and 111: digit zero
    endcase
  end

  // R3: a digit never selects both magnitudes
  always_comb begin
    assert_sel_onehot_R3: assert ($onehot0({sel_o.one, sel_o.two}));
  end

endmodule

// File: rtl/booth_row_sel.sv
module booth_row_sel
  import booth_pp_pkg::*;
#(
  parameter int YW = 6
) (
  input  logic [YW-1:0] y_i,
  input  booth_sel_t    sel_i,
  output logic [YW:0]   bits_o
);

  localparam int YEW = YW + 2;

  // multiplicand with a zero below and its sign repeated above
  logic [YEW-1:0] y_ext;
  assign y_ext = {y_i[YW-1], y_i, 1'b0};

  // bit j: y_ext[j+1] is the plain bit, y_ext[j] the shifted one
  assign bits_o = (({(YW+1){sel_i.one}} & y_ext[YEW-1:1]) |
                   ({(YW+1){sel_i.two}} & y_ext[YEW-2:0])) ^
                  {(YW+1){sel_i.neg}};

endmodule

// File: rtl/booth_pp_gen.sv
module booth_pp_gen
  import booth_pp_pkg::*;
#(
  parameter int XW = 5,
  parameter int YW = 6
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              in_valid,
  input  logic [XW-1:0]                     x_i,
  input  logic [YW-1:0]                     y_i,
  output logic                              out_valid,
  output logic [((XW+1)/2)*(XW+YW)-1:0]     rows_o,
  output logic [((XW+1)/2)-1:0]             neg_o
);

  localparam int PW  = XW + YW;
  localparam int NR  = (XW + 1) / 2;
  localparam int XEW = 2 * NR + 1;

  // multiplier with a zero appended below and, for odd widths, a sign bit above
  logic [XEW-1:0] x_ext;
  generate
    if (XEW > XW + 1) begin : g_x_odd
      assign x_ext = {x_i[XW-1], x_i, 1'b0};
    end else begin : g_x_even
      assign x_ext = {x_i, 1'b0};
    end
  endgenerate

  logic [PW-1:0] row_next [NR];
  logic [NR-1:0] neg_next;

  generate
    for (genvar r = 0; r < NR; r++) begin : g_row
      booth_sel_t    sel;
      logic [YW:0]   bits;
      logic [PW-1:0] seed;

      booth_digit_dec u_dec (
        .trip_i (x_ext[2*r+2 -: 3]),
        .sel_o  (sel)
      );

      booth_row_sel #(.YW(YW)) u_sel (
        .y_i    (y_i),
        .sel_i  (sel),
        .bits_o (bits)
      );

      if (r == 0) begin : g_first
        // top bit copied once, then its inverse
        always_comb begin
          seed = '0;
          seed[YW+2:0] = {~bits[YW], bits[YW], bits};
        end
      end else begin : g_rest
        // inverted top bit with a constant one above it
        always_comb begin
          seed = '0;
          seed[YW+1:0] = {1'b1, ~bits[YW], bits[YW-1:0]};
        end
      end

      // bits shifted past PW are dropped here
      assign row_next[r] = seed << (2 * r);
      assign neg_next[r] = sel.neg;
    end
  endgenerate

  logic [PW-1:0] row_q [NR];
  logic [NR-1:0] neg_q;
  logic          valid_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int r = 0; r < NR; r++) row_q[r] <= '0;
      neg_q   <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= in_valid;
      if (in_valid) begin
        for (int r = 0; r < NR; r++) row_q[r] <= row_next[r];
        neg_q <= neg_next;
      end
    end
  end

  generate
    for (genvar r = 0; r < NR; r++) begin : g_out
      assign rows_o[r*PW +: PW] = row_q[r];
    end
  endgenerate

  assign neg_o     = neg_q;
  assign out_valid = valid_q;

  // ---------------- assertions ----------------

  assert_latency_R2: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && $stable(rows_o) && $stable(neg_o)));

  assert_zero_mult_R4: assert property (@(posedge clk) disable iff (rst)
    (in_valid && x_i == '0) |=> (neg_o == '0));

  assert_first_ext_R6: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (rows_o[YW+1] == rows_o[YW] && rows_o[YW+2] != rows_o[YW+1]));

  generate
    for (genvar r = 1; r < NR; r++) begin : g_chk
      if (2*r + YW + 1 < PW) begin : g_const
        assert_const_one_R7: assert property (@(posedge clk) disable iff (rst)
          out_valid |-> rows_o[r*PW + 2*r + YW + 1]);
      end
    end
  endgenerate

endmodule

// File: tb/tb_booth_pp_gen.sv
module tb_booth_pp_gen;

  localparam int XW = 5;
  localparam int YW = 6;
  localparam int PW = XW + YW;
  localparam int NR = (XW + 1) / 2;

  logic              clk = 1'b0;
  logic              rst;
  logic              in_valid;
  logic [XW-1:0]     x;
  logic [YW-1:0]     y;
  logic              out_valid;
  logic [NR*PW-1:0]  rows;
  logic [NR-1:0]     neg;

  booth_pp_gen #(.XW(XW), .YW(YW)) dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .x_i(x), .y_i(y),
    .out_valid(out_valid), .rows_o(rows), .neg_o(neg)
  );

  always #5 clk = ~clk;   // 100 MHz

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;
  bit started  = 1'b0;
  bit have_last = 1'b0;
  logic [NR*PW-1:0] last_rows;
  logic [NR-1:0]    last_neg;

  typedef struct {
    logic [XW-1:0] xv;
    logic [YW-1:0] yv;
  } item_t;
  item_t sb[$];

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [XW-1:0] xv, input logic [YW-1:0] yv);
    @(posedge clk); #2;
    x = xv; y = yv; in_valid = 1'b1;
    sb.push_back('{xv, yv});
  endtask

  task automatic idle(input logic [XW-1:0] xv, input logic [YW-1:0] yv);
    @(posedge clk); #2;
    x = xv; y = yv; in_valid = 1'b0;
  endtask

  task automatic judge(input item_t it);
    logic [XW+1:0] xe;
    longint sx, sy, sum, prodm, mask;
    xe    = {it.xv[XW-1], it.xv, 1'b0};
    sx    = longint'($signed(it.xv));
    sy    = longint'($signed(it.yv));
    mask  = (longint'(1) << PW) - 1;
    sum   = 0;
    for (int r = 0; r < NR; r++) begin
      longint row, v, vb, d, topb;
      row = longint'(rows[r*PW +: PW]);
      d   = -2 * longint'(xe[2*r+2]) + longint'(xe[2*r+1]) + longint'(xe[2*r]);
      v   = (d < 0) ? ~((-d) * sy) : d * sy;
      vb  = v & ((longint'(1) << (YW+1)) - 1);
      topb = (vb >> YW) & 1;
      check(neg[r] == (d < 0), "R4 negation flag", longint'(neg[r]), longint'(d < 0));
      check((row & ((longint'(1) << (2*r)) - 1)) == 0, "R5 bits below row base",
            row & ((longint'(1) << (2*r)) - 1), 0);
      check(((row >> (2*r)) & ((longint'(1) << YW) - 1)) == (vb & ((longint'(1) << YW) - 1)),
            "R3 selected bits", (row >> (2*r)) & ((longint'(1) << YW) - 1),
            vb & ((longint'(1) << YW) - 1));
      if (r == 0) begin
        check(((row >> YW) & 1) == topb, "R3 row0 top bit", (row >> YW) & 1, topb);
        check(((row >> (YW+1)) & 1) == topb, "R6 copied top bit", (row >> (YW+1)) & 1, topb);
        check(((row >> (YW+2)) & 1) == (topb ^ 1), "R6 inverted top bit",
              (row >> (YW+2)) & 1, topb ^ 1);
        check((row >> (YW+3)) == 0, "R6 upper bits zero", row >> (YW+3), 0);
      end else begin
        if (2*r + YW < PW)
          check(((row >> (2*r+YW)) & 1) == (topb ^ 1), "R7 inverted top bit",
                (row >> (2*r+YW)) & 1, topb ^ 1);
        if (2*r + YW + 1 < PW)
          check(((row >> (2*r+YW+1)) & 1) == 1, "R7 constant one",
                (row >> (2*r+YW+1)) & 1, 1);
        if (2*r + YW + 2 < PW)
          check((row >> (2*r+YW+2)) == 0, "R7 upper bits zero", row >> (2*r+YW+2), 0);
      end
      sum = sum + row + (longint'(neg[r]) << (2*r));
    end
    prodm = (sx * sy) & mask;
    check((sum & mask) == prodm, "R8 modular sum equals product", sum & mask, prodm);
  endtask

  // monitor: pops the scoreboard as results appear
  always @(negedge clk) begin
    if (started && !rst) begin
      if (out_valid) begin
        if (sb.size() == 0) begin
          check(1'b0, "R2 result without pending input", 1, 0);
        end else begin
          judge(sb.pop_front());
        end
        last_rows = rows;
        last_neg  = neg;
        have_last = 1'b1;
      end else if (have_last) begin
        check(rows == last_rows, "R2 rows hold when idle", longint'(rows), longint'(last_rows));
        check(neg == last_neg, "R2 flags hold when idle", longint'(neg), longint'(last_neg));
      end
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    #1000000;
    fails++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    int n;
    rst = 1'b1; in_valid = 1'b1; x = '1; y = '1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(out_valid == 1'b0, "R1 reset valid", longint'(out_valid), 0);
    check(rows == '0, "R1 reset rows", longint'(rows), 0);
    check(neg == '0, "R1 reset flags", longint'(neg), 0);
    @(posedge clk); #2;
    rst = 1'b0; in_valid = 1'b0;
    started = 1'b1;
    n = 0;
    for (int xi = 0; xi < (1 << XW); xi++) begin
      for (int yi = 0; yi < (1 << YW); yi++) begin
        drive(XW'(xi), YW'(yi));
        n++;
        if (n % 13 == 0) idle(XW'(xi + 3), YW'(yi + 5));
      end
    end
    idle('0, '0);
    idle('1, '1);
    repeat (3) @(posedge clk);
    check(sb.size() == 0, "R2 every input produced a result", longint'(sb.size()), 0);
    finish_run();
  end

endmodule